// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the combinational arithmetic and logic unit of a legacy-style 8/16-bit integer datapath. Each evaluation takes a destination operand, a source operand, an operation code, a width select and the incoming carry flag. It returns a result, a write request that says whether the result should be stored back, a five-bit flag vector, and a mask that marks which flags the operation actually changes.

Eleven operations are supported: add, subtract, compare, increment, decrement, bitwise AND, OR and XOR, test, one's complement and two's-complement negate. Each operation has its own flag policy. Compare and test update flags but never request a write. Increment and decrement leave the carry flag as it arrived. The logic operations clear carry and overflow. The two unary complements write a result and change no flag at all. The surrounding pipeline commits `res_o` when `we_o` is high and merges `flags_o` into its flag register under `fmask_o`.

Top module: `alu_core`

## Requirements
- R1: ADD (op 0) gives dst+src and SUB (op 1) gives dst-src, both with we_o=1 and all five flags in the mask; CF is the carry out for add and the borrow (dst<src unsigned) for subtract; OF is set when the signed result does not fit in the selected width.
- R2: CMP (op 2) produces the same result and flags as SUB but drives we_o=0; for example 8-bit 0xC0 minus 0xC3 gives 0xFD with CF=1, ZF=0, and 0xC0 minus 0x73 gives 0x4D with OF=1, SF=0, CF=0.
- R3: INC (op 3) adds 1 and DEC (op 4) subtracts 1 with we_o=1; OF, SF, ZF and PF are in the mask, the CF mask bit is 0 and the CF output equals cf_i.
- R4: AND (op 5), OR (op 6) and XOR (op 7) work bit by bit with we_o=1, all five flags in the mask, and CF=0 and OF=0 whatever cf_i is.
- R5: TEST (op 8) produces the AND of the operands with the same flags as AND but drives we_o=0.
- R6: NOT (op 9) gives the one's complement of dst_i with we_o=1 and an all-zero flag mask.
- R7: NEG (op 10) gives 0 minus dst_i with we_o=1 and an all-zero flag mask.
- R8: With wide_i=0 only bits 7:0 of the operands take part, result bits 15:8 are 0, SF is result bit 7 and the carry and overflow come from the 8-bit operation; with wide_i=1 all 16 bits take part and SF is bit 15.
- R9: ZF is set when the result in the selected width is zero; PF is set when result bits 7:0 hold an even number of ones.
- R10: flags_o and fmask_o use bit 0 CF, bit 1 PF, bit 2 ZF, bit 3 SF, bit 4 OF; flag bits outside the mask are 0 except bit 0, which then repeats cf_i; op codes 11 to 15 give res_o=0, we_o=0 and fmask_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 16 | Destination operand; the only operand of NOT and NEG |
| src_i | input | 16 | Source operand |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| cf_i | input | 1 | Carry flag before the operation |
| res_o | output | 16 | Result, zero-extended in 8-bit mode |
| we_o | output | 1 | Request to store the result |
| flags_o | output | 5 | Flag values {OF, SF, ZF, PF, CF} |
| fmask_o | output | 5 | Flags changed by this operation, same layout |

## Verification
Add and subtract are driven with pairs that overflow only as signed values, wrap only as unsigned values, and land exactly on zero, which separates the carry, overflow and zero paths. The compare vectors reuse the unsigned greater, less and equal cases plus a signed case where overflow and sign disagree, so a swapped borrow polarity or a wrong overflow term shows up. Increment and decrement run with cf_i both set and clear across the wrap points, proving carry passes through untouched, and narrow-mode vectors carry junk in the upper bytes to show it cannot leak into result or flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_NOT  = 4'd9,
    OP_NEG  = 4'd10
  } alu_op_e;

  // bit 0 carry, bit 1 parity, bit 2 zero, bit 3 sign, bit 4 overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic par;
    logic cry;
  } alu_flags_t;

  localparam int unsigned FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          wide_i,
  output logic [DW-1:0] sum_o,
  output logic          cf_o,
  output logic          of_o
);

  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] wmask;
  logic [DW-1:0] am;
  logic [DW-1:0] bm;
  logic [DW:0]   full;
  logic          cout;
  logic          sa, sb, ss;

  always_comb begin
    wmask = wide_i ? '1 : NMASK;
    am    = a_i & wmask;
    bm    = (sub_i ? ~b_i : b_i) & wmask;
    full  = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, sub_i};
    sum_o = full[DW-1:0] & wmask;
    cout  = wide_i ? full[DW] : full[NW];
    // a subtract reports a borrow, the inverse of the adder carry
    cf_o  = cout ^ sub_i;
    sa    = wide_i ? am[DW-1]    : am[NW-1];
    sb    = wide_i ? bm[DW-1]    : bm[NW-1];
    ss    = wide_i ? sum_o[DW-1] : sum_o[NW-1];
    of_o  = (sa == sb) && (ss != sa);
  end

  always_comb begin
    // R1
    if (wide_i && !sub_i) begin
      add_carry_wrap_chk: assert (cf_o == (sum_o < a_i));
    end
    // R1
    if (wide_i && sub_i) begin
      sub_borrow_cmp_chk: assert (cf_o == (a_i < b_i));
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o
);

  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] raw;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TEST: raw = a_i & b_i;
      OP_OR:           raw = a_i | b_i;
      OP_XOR:          raw = a_i ^ b_i;
      OP_NOT:          raw = ~a_i;
      default:         raw = '0;
    endcase
    res_o = raw & (wide_i ? '1 : NMASK);
  end

endmodule

// File: rtl/alu_flagcalc.sv
module alu_flagcalc #(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8
) (
  input  logic [DW-1:0] res_i,
  input  logic          wide_i,
  output logic          zf_o,
  output logic          sf_o,
  output logic          pf_o
);

  localparam int unsigned PW = (NW < 8) ? NW : 8;

  logic [PW-1:0] ones;

  // parity chain over the low byte of the result
  for (genvar g = 0; g < PW; g++) begin : g_par
    if (g == 0) begin : g_first
      assign ones[g] = res_i[g];
    end else begin : g_next
      assign ones[g] = ones[g-1] ^ res_i[g];
    end
  end

  always_comb begin
    zf_o = wide_i ? (res_i == '0) : (res_i[NW-1:0] == '0);
    sf_o = wide_i ? res_i[DW-1] : res_i[NW-1];
    pf_o = ~ones[PW-1];
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8
) (
  input  logic [DW-1:0]     dst_i,
  input  logic [DW-1:0]     src_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              cf_i,
  output logic [DW-1:0]     res_o,
  output logic              we_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] fmask_o
);

  localparam logic [DW-1:0]     ONE       = DW'(1);
  localparam logic [FLAG_W-1:0] MASK_ALL  = '1;
  localparam logic [FLAG_W-1:0] MASK_NOCF = {{(FLAG_W-1){1'b1}}, 1'b0};

  alu_op_e       op;
  logic [DW-1:0] add_a, add_b, add_sum;
  logic          add_sub, add_cf, add_of;
  logic [DW-1:0] log_res;
  logic          use_logic;
  logic [DW-1:0] lane_res;
  logic          zf, sf, pf;
  alu_flags_t    fl;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder
  always_comb begin
    add_a   = dst_i;
    add_b   = src_i;
    add_sub = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: add_sub = 1'b1;
      OP_INC:         add_b   = ONE;
      OP_DEC: begin
        add_b   = ONE;
        add_sub = 1'b1;
      end
      OP_NEG: begin
        add_a   = '0;
        add_b   = dst_i;
        add_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu_addsub #(.DW(DW), .NW(NW)) addsub_i (
    .a_i    (add_a),
    .b_i    (add_b),
    .sub_i  (add_sub),
    .wide_i (wide_i),
    .sum_o  (add_sum),
    .cf_o   (add_cf),
    .of_o   (add_of)
  );

  alu_logic #(.DW(DW), .NW(NW)) logic_i (
    .op_i   (op),
    .a_i    (dst_i),
    .b_i    (src_i),
    .wide_i (wide_i),
    .res_o  (log_res)
  );

  always_comb begin
    use_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                (op == OP_TEST) || (op == OP_NOT);
    lane_res  = use_logic ? log_res : add_sum;
  end

  alu_flagcalc #(.DW(DW), .NW(NW)) flagcalc_i (
    .res_i  (lane_res),
    .wide_i (wide_i),
    .zf_o   (zf),
    .sf_o   (sf),
    .pf_o   (pf)
  );

  // per-operation write and flag policy
  always_comb begin
    res_o   = '0;
    we_o    = 1'b0;
    fmask_o = '0;
    fl      = '{ovf: 1'b0, sgn: 1'b0, zro: 1'b0, par: 1'b0, cry: cf_i};
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        res_o   = add_sum;
        we_o    = (op != OP_CMP);
        fmask_o = MASK_ALL;
        fl      = '{ovf: add_of, sgn: sf, zro: zf, par: pf, cry: add_cf};
      end
      OP_INC, OP_DEC: begin
        res_o   = add_sum;
        we_o    = 1'b1;
        fmask_o = MASK_NOCF;
        fl      = '{ovf: add_of, sgn: sf, zro: zf, par: pf, cry: cf_i};
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        res_o   = log_res;
        we_o    = (op != OP_TEST);
        fmask_o = MASK_ALL;
        fl      = '{ovf: 1'b0, sgn: sf, zro: zf, par: pf, cry: 1'b0};
      end
      OP_NOT: begin
        res_o = log_res;
        we_o  = 1'b1;
      end
      OP_NEG: begin
        res_o = add_sum;
        we_o  = 1'b1;
      end
      default: ;
    endcase
    flags_o = fl;
  end

  always_comb begin
    // R2
    if (op_i == OP_CMP) begin
      cmp_nowrite_chk: assert (!we_o && fmask_o == MASK_ALL);
    end
    // R5
    if (op_i == OP_TEST) begin
      test_nowrite_chk: assert (!we_o && flags_o[0] == 1'b0 && flags_o[4] == 1'b0);
    end
    // R3
    if (op_i == OP_INC || op_i == OP_DEC) begin
      incdec_carry_hold_chk: assert (flags_o[0] == cf_i && !fmask_o[0]);
    end
    // R4
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
      logic_clear_cf_of_chk: assert (we_o && flags_o[0] == 1'b0 && flags_o[4] == 1'b0);
    end
    // R6
    if (op_i == OP_NOT || op_i == OP_NEG) begin
      unary_no_flags_chk: assert (we_o && fmask_o == '0);
    end
    // R8
    if (!wide_i) begin
      narrow_upper_zero_chk: assert (res_o[DW-1:NW] == '0);
    end
    // R9
    if (fmask_o[2]) begin
      zero_flag_match_chk: assert (flags_o[2] == (res_o == '0));
    end
    // R10
    if (op_i > 4'd10) begin
      undef_op_idle_chk: assert (!we_o && fmask_o == '0 && res_o == '0);
    end
  end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;
  import alu_pkg::*;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [4:0]  flags;
    logic [4:0]  fmask;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] dst, src;
  logic [3:0]  op;
  logic        wide, cfin;
  logic [15:0] res;
  logic        we;
  logic [4:0]  flags, fmask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q[$];

  alu_core dut_i (
    .dst_i   (dst),
    .src_i   (src),
    .op_i    (op),
    .wide_i  (wide),
    .cf_i    (cfin),
    .res_o   (res),
    .we_o    (we),
    .flags_o (flags),
    .fmask_o (fmask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model built from the requirement text, integer arithmetic
  function automatic exp_t model(input int o, input bit w16, input int d,
                                 input int s, input bit c, input string tag);
    exp_t e;
    int w    = w16 ? 16 : 8;
    int m    = (1 << w) - 1;
    int half = 1 << (w - 1);
    int a    = d & m;
    int b    = s & m;
    int sa   = (a >= half) ? a - (1 << w) : a;
    int sb   = (b >= half) ? b - (1 << w) : b;
    int r    = 0;
    int sr   = 0;
    bit cfo  = c;
    bit ofo  = 0;
    bit zf, sf, pf;
    e.tag = tag;
    e.we = 0;
    e.fmask = 5'b0;
    case (o)
      0: begin r = a + b; sr = sa + sb; cfo = (r > m); e.we = 1; e.fmask = 5'b11111; end
      1, 2: begin r = a - b; sr = sa - sb; cfo = (a < b); e.we = (o == 1); e.fmask = 5'b11111; end
      3: begin r = a + 1; sr = sa + 1; e.we = 1; e.fmask = 5'b11110; end
      4: begin r = a - 1; sr = sa - 1; e.we = 1; e.fmask = 5'b11110; end
      5, 8: begin r = a & b; cfo = 0; e.we = (o == 5); e.fmask = 5'b11111; end
      6: begin r = a | b; cfo = 0; e.we = 1; e.fmask = 5'b11111; end
      7: begin r = a ^ b; cfo = 0; e.we = 1; e.fmask = 5'b11111; end
      9: begin r = ~a; e.we = 1; end
      10: begin r = -a; e.we = 1; end
      default: r = 0;
    endcase
    r   = r & m;
    if (o <= 4) ofo = (sr >= half) || (sr < -half);
    zf  = (r == 0);
    sf  = (r >> (w - 1)) & 1;
    pf  = ~^(r[7:0]);
    e.res = r[15:0];
    if (e.fmask == 5'b0) e.flags = {4'b0, c};
    else e.flags = {ofo, sf, zf, pf, cfo};
    return e;
  endfunction

  task automatic drive(input int o, input bit w16, input int d, input int s,
                       input bit c, input string tag);
    @(posedge clk);
    #1;
    op   = o[3:0];
    wide = w16;
    dst  = d[15:0];
    src  = s[15:0];
    cfin = c;
    q.push_back(model(o, w16, d, s, c, tag));
  endtask

  // monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.res || we !== e.we || flags !== e.flags || fmask !== e.fmask) begin
        fails++;
        $display("FAIL %s: res=%h we=%b flags=%b mask=%b, expected res=%h we=%b flags=%b mask=%b",
                 e.tag, res, we, flags, fmask, e.res, e.we, e.flags, e.fmask);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    dst = '0; src = '0; op = '0; wide = 1'b0; cfin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs, op 0 in narrow mode
    drive(0, 0, 'h0000, 'h0000, 0, "R1 reset-state");
    // R1 add and subtract
    drive(0, 0, 'h007F, 'h0001, 0, "R1 add signed overflow");
    drive(0, 1, 'hFFFF, 'h0001, 0, "R1 add unsigned wrap");
    drive(1, 0, 'h00C3, 'h00C0, 1, "R1 sub");
    drive(1, 1, 'h8000, 'h0001, 0, "R1 sub signed overflow");
    // R2 compare
    drive(2, 0, 'h00C3, 'h00C0, 0, "R2 cmp greater");
    drive(2, 0, 'h00C0, 'h00C3, 0, "R2 cmp less");
    drive(2, 0, 'h00C3, 'h00C3, 1, "R2 cmp equal");
    drive(2, 0, 'h00C0, 'h0073, 0, "R2 cmp signed");
    drive(2, 1, 'h1234, 'h5678, 0, "R2 cmp wide");
    // R3 increment and decrement keep carry
    drive(3, 0, 'h007F, 'h0000, 1, "R3 inc overflow");
    drive(3, 0, 'h00FF, 'h0000, 0, "R3 inc wrap");
    drive(4, 1, 'h0000, 'h0000, 1, "R3 dec wrap");
    drive(4, 0, 'h0080, 'h0000, 0, "R3 dec overflow");
    // R4 logic operations
    drive(5, 1, 'hF0F0, 'h0FF0, 1, "R4 and");
    drive(6, 0, 'h0081, 'h0002, 1, "R4 or");
    drive(7, 1, 'hA5A5, 'hA5A5, 1, "R4 xor zero");
    // R5 test
    drive(8, 0, 'h00F3, 'h0081, 1, "R5 test");
    // R6 and R7 unary
    drive(9, 1, 'h1234, 'h0000, 1, "R6 not");
    drive(10, 0, 'h0001, 'h0000, 0, "R7 neg");
    drive(10, 1, 'h0000, 'h0000, 1, "R7 neg zero");
    // R8 narrow mode ignores upper bytes
    drive(0, 0, 'h12FF, 'h3401, 0, "R8 narrow upper ignored");
    drive(7, 0, 'hFF00, 'h0080, 0, "R8 narrow sign bit");
    // R9 parity of low byte
    drive(7, 1, 'h0100, 'h0003, 0, "R9 parity even");
    drive(6, 1, 'h0700, 'h0001, 0, "R9 parity odd");
    // R10 undefined codes
    drive(13, 1, 'hFFFF, 'hFFFF, 1, "R10 undefined op");
    drive(15, 0, 'h00AA, 'h0055, 0, "R10 undefined op");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule